// File: doc/BRIEF.md
# Video-Mode Frame and Line Timing Sequencer

This block produces the timing skeleton for a video-mode serial display link. It counts in lane byte clock cycles. Each frame passes through four vertical regions and each line through four horizontal regions. The vertical regions are sync, back porch, active and front porch. The horizontal regions are sync, back porch, active and front porch, and the front porch takes whatever is left of the programmed line time. From these regions the block derives a line-start flag and a frame-start flag. It also derives a strobe that marks the first cycle of every active-line payload and carries the programmed packet width in pixels. A low-power-permitted flag is chosen per region from a set of enable bits. An optional request for a bus turnaround acknowledge is raised on the last cycle of every frame.

All configuration arrives on plain input pins. The block copies the pins into shadow registers only at the edge that starts a frame, so reprogramming can never tear a frame. Pixel data, packet assembly and PHY control belong to neighbouring blocks. Those blocks read the region flags and strobes here and have no way to stall this block. The block has no valid/ready handshake: the strobe is a timing mark that carries no payload, and the link timing cannot accept back-pressure.

Top module: `dvt_vid_timing`

## Requirements
- R1: While reset is asserted, and whenever `active` is low, all outputs are zero. Region value 0 means sync.
- R2: When `run_en` is high at a clock edge while idle, the next cycle is the first cycle of a frame: `active`=1, `frame_start`=1 and `line_start`=1. `frame_start` is high exactly on the first cycle of every frame.
- R3: A line lasts max(`cfg_hline`,1) cycles. At cycle offset p within the line, `h_region` is 0 (sync) if p < hsa, 1 (back porch) if p < hsa+hbp, 2 (active) if p < hsa+hbp+hact, and 3 (front porch) otherwise. `line_start` is high at p=0.
- R4: A frame lasts max(vsa+vbp+vact+vfp,1) lines. At line index L, `v_region` is decoded from L with the same 0..3 encoding and the vertical counts. If all counts are zero, the single line is front porch.
- R5: A region with zero length is skipped and takes no cycle: the next nonzero region starts on the cycle where the empty one would have started.
- R6: Configuration pins are sampled only at the edge that starts a frame. Changes during a frame do not affect timing, the packet width, the low-power enables or the turnaround enable until the next frame.
- R7: `pkt_start` pulses on the cycle where p = hsa+hbp of a vertical-active line, provided hact > 0 and that cycle falls inside the line. `pkt_px` then equals the sampled `cfg_pkt_px`, and it is zero on every other cycle.
- R8: `lp_ok` uses `cfg_lp_en` bit 0 in vertical sync, bit 1 in vertical back porch and bit 3 in vertical front porch, each applying to the whole line. In vertical active lines, `lp_ok` = bit 2 AND bit 4 during horizontal back porch, bit 2 AND bit 5 during horizontal front porch, and 0 during horizontal sync and active.
- R9: `bta_req` is high on the last cycle of every frame when the sampled `cfg_bta_en` is 1, and low otherwise.
- R10: When `run_en` is low at a clock edge, the block is idle (`active`=0) in the following cycle, and its counters restart from zero when it is next enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run the sequencer; low forces idle |
| cfg_hsa | input | HW | Horizontal sync length, cycles |
| cfg_hbp | input | HW | Horizontal back porch length, cycles |
| cfg_hact | input | HW | Horizontal active length, cycles |
| cfg_hline | input | HW | Total line length, cycles |
| cfg_vsa | input | VW | Vertical sync lines |
| cfg_vbp | input | VW | Vertical back porch lines |
| cfg_vact | input | VW | Vertical active lines |
| cfg_vfp | input | VW | Vertical front porch lines |
| cfg_pkt_px | input | PW | Active packet width in pixels |
| cfg_lp_en | input | 6 | Low-power enables, bit map in R8 |
| cfg_bta_en | input | 1 | Enable end-of-frame turnaround request |
| active | output | 1 | Sequencer is running a frame |
| v_region | output | 2 | Vertical region code |
| h_region | output | 2 | Horizontal region code |
| frame_start | output | 1 | First cycle of a frame |
| line_start | output | 1 | First cycle of a line |
| pkt_start | output | 1 | First cycle of an active-line payload |
| pkt_px | output | PW | Packet width, valid with `pkt_start` |
| lp_ok | output | 1 | Low-power state permitted this cycle |
| bta_req | output | 1 | End-of-frame turnaround request |

## Verification
On every cycle the assertions check the following. The outputs are quiet when idle. A packet strobe only appears inside the active window of an active line. Region codes never move backwards within a line or a frame. A turnaround request is always followed by a new frame or by idle. Low-power permission never appears during horizontal sync or active of an active line. The exact region boundaries, zero-length skipping, frame length, deferral of configuration to the frame edge, and the value of the low-power flag under each enable pattern are only shown by the bench's reference model, which is compared with the design on every clock across several configurations.

// File: rtl/dvt_pkg.sv
package dvt_pkg;
  typedef enum logic [1:0] {
    RG_SYNC = 2'd0,
    RG_BP   = 2'd1,
    RG_ACT  = 2'd2,
    RG_FP   = 2'd3
  } region_e;

  localparam int LPB_VSA  = 0;
  localparam int LPB_VBP  = 1;
  localparam int LPB_VACT = 2;
  localparam int LPB_VFP  = 3;
  localparam int LPB_HBP  = 4;
  localparam int LPB_HFP  = 5;
  localparam int LP_BITS  = 6;
endpackage

// File: rtl/dvt_shadow.sv
module dvt_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dvt_frame_ctr.sv
module dvt_frame_ctr #(
  parameter int HW  = 12,
  parameter int VSW = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic [HW-1:0]  hlen_m1,
  input  logic [VSW-1:0] vtot_m1,
  output logic           running,
  output logic [HW-1:0]  hcnt,
  output logic [VSW-1:0] vline,
  output logic           line_last,
  output logic           frame_last,
  output logic           load
);
  assign line_last  = running && (hcnt == hlen_m1);
  assign frame_last = line_last && (vline == vtot_m1);
  assign load       = run_en && (!running || frame_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      hcnt    <= '0;
      vline   <= '0;
    end else if (!run_en) begin
      running <= 1'b0;
      hcnt    <= '0;
      vline   <= '0;
    end else if (!running) begin
      running <= 1'b1;
      hcnt    <= '0;
      vline   <= '0;
    end else if (line_last) begin
      hcnt  <= '0;
      vline <= frame_last ? '0 : vline + VSW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end
endmodule

// File: rtl/dvt_region_dec.sv
module dvt_region_dec
  import dvt_pkg::*;
#(
  parameter int W    = 12,
  parameter int POSW = 12
) (
  input  logic [POSW-1:0] pos,
  input  logic [W-1:0]    len_sync,
  input  logic [W-1:0]    len_bp,
  input  logic [W-1:0]    len_act,
  output region_e         region
);
  localparam int SW = ((W > POSW) ? W : POSW) + 2;

  logic [SW-1:0] end_sync, end_bp, end_act, p;

  assign p        = SW'(pos);
  assign end_sync = SW'(len_sync);
  assign end_bp   = end_sync + SW'(len_bp);
  assign end_act  = end_bp + SW'(len_act);

  always_comb begin
    if (p < end_sync)     region = RG_SYNC;
    else if (p < end_bp)  region = RG_BP;
    else if (p < end_act) region = RG_ACT;
    else                  region = RG_FP;
  end
endmodule

// File: rtl/dvt_vid_timing.sv
module dvt_vid_timing
  import dvt_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [HW-1:0] cfg_hsa,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hact,
  input  logic [HW-1:0] cfg_hline,
  input  logic [VW-1:0] cfg_vsa,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vfp,
  input  logic [PW-1:0] cfg_pkt_px,
  input  logic [5:0]    cfg_lp_en,
  input  logic          cfg_bta_en,
  output logic          active,
  output logic [1:0]    v_region,
  output logic [1:0]    h_region,
  output logic          frame_start,
  output logic          line_start,
  output logic          pkt_start,
  output logic [PW-1:0] pkt_px,
  output logic          lp_ok,
  output logic          bta_req
);
  localparam int VSW  = VW + 2;
  localparam int HSW  = HW + 1;
  localparam int CFGW = 4*HW + 4*VW + PW + LP_BITS + 1;

  // ---------------- shadow configuration, loaded at frame start
  logic [CFGW-1:0] cfg_bus, sh_bus;
  logic [HW-1:0]   sh_hsa, sh_hbp, sh_hact, sh_hline;
  logic [VW-1:0]   sh_vsa, sh_vbp, sh_vact, sh_vfp;
  logic [PW-1:0]   sh_px;
  logic [LP_BITS-1:0] sh_lp;
  logic            sh_bta;
  logic            load;

  assign cfg_bus = {cfg_hsa, cfg_hbp, cfg_hact, cfg_hline,
                    cfg_vsa, cfg_vbp, cfg_vact, cfg_vfp,
                    cfg_pkt_px, cfg_lp_en, cfg_bta_en};
  assign {sh_hsa, sh_hbp, sh_hact, sh_hline,
          sh_vsa, sh_vbp, sh_vact, sh_vfp,
          sh_px, sh_lp, sh_bta} = sh_bus;

  dvt_shadow #(.W(CFGW)) i_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (cfg_bus),
    .q     (sh_bus)
  );

  // ---------------- line and frame lengths
  logic [HW-1:0]  hlen_m1;
  logic [VSW-1:0] vsum, vtot_m1;

  assign hlen_m1 = (sh_hline == '0) ? '0 : sh_hline - HW'(1);
  assign vsum    = VSW'(sh_vsa) + VSW'(sh_vbp) + VSW'(sh_vact) + VSW'(sh_vfp);
  assign vtot_m1 = (vsum == '0) ? '0 : vsum - VSW'(1);

  // ---------------- counters
  logic           running, line_last, frame_last;
  logic [HW-1:0]  hcnt;
  logic [VSW-1:0] vline;

  dvt_frame_ctr #(.HW(HW), .VSW(VSW)) i_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .hlen_m1    (hlen_m1),
    .vtot_m1    (vtot_m1),
    .running    (running),
    .hcnt       (hcnt),
    .vline      (vline),
    .line_last  (line_last),
    .frame_last (frame_last),
    .load       (load)
  );

  // ---------------- region decode
  region_e hreg, vreg;

  dvt_region_dec #(.W(HW), .POSW(HW)) i_hdec (
    .pos      (hcnt),
    .len_sync (sh_hsa),
    .len_bp   (sh_hbp),
    .len_act  (sh_hact),
    .region   (hreg)
  );

  dvt_region_dec #(.W(VW), .POSW(VSW)) i_vdec (
    .pos      (vline),
    .len_sync (sh_vsa),
    .len_bp   (sh_vbp),
    .len_act  (sh_vact),
    .region   (vreg)
  );

  // ---------------- packet start
  logic [HSW-1:0] act_off;
  logic           at_act_off;

  assign act_off    = HSW'(sh_hsa) + HSW'(sh_hbp);
  assign at_act_off = (HSW'(hcnt) == act_off) && (sh_hact != '0);

  // ---------------- low-power permission
  logic lp_sel;

  always_comb begin
    unique case (vreg)
      RG_SYNC: lp_sel = sh_lp[LPB_VSA];
      RG_BP:   lp_sel = sh_lp[LPB_VBP];
      RG_FP:   lp_sel = sh_lp[LPB_VFP];
      default: lp_sel = sh_lp[LPB_VACT] &&
                        (((hreg == RG_BP) && sh_lp[LPB_HBP]) ||
                         ((hreg == RG_FP) && sh_lp[LPB_HFP]));
    endcase
  end

  // ---------------- outputs
  assign active      = running;
  assign v_region    = running ? vreg : RG_SYNC;
  assign h_region    = running ? hreg : RG_SYNC;
  assign line_start  = running && (hcnt == '0);
  assign frame_start = line_start && (vline == '0);
  assign pkt_start   = running && (vreg == RG_ACT) && at_act_off;
  assign pkt_px      = pkt_start ? sh_px : '0;
  assign lp_ok       = running && lp_sel;
  assign bta_req     = frame_last && sh_bta;
endmodule

// File: rtl/dvt_vid_timing_chk.sv
module dvt_vid_timing_chk #(
  parameter int PW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          active,
  input logic [1:0]    v_region,
  input logic [1:0]    h_region,
  input logic          frame_start,
  input logic          line_start,
  input logic          pkt_start,
  input logic [PW-1:0] pkt_px,
  input logic          lp_ok,
  input logic          bta_req
);
  // R1: idle outputs are quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (v_region == 2'd0 && h_region == 2'd0 && !frame_start &&
                 !line_start && !pkt_start && !lp_ok && !bta_req));

  // R2: a frame start is also a line start
  a_r2_frame_is_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);

  // R3: horizontal regions never step backwards inside a line
  a_r3_h_order: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !line_start) |-> (h_region >= $past(h_region)));

  // R4: vertical regions never step backwards inside a frame
  a_r4_v_order: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !frame_start) |-> (v_region >= $past(v_region)));

  // R7: packet strobe only in the active window of an active line
  a_r7_pkt_window: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (h_region == 2'd2 && v_region == 2'd2));

  // R7: packet width only accompanies the strobe
  a_r7_px_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_start |-> (pkt_px == '0));

  // R8: no low-power during horizontal sync or active of an active line
  a_r8_lp_window: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_ok && v_region == 2'd2) |-> (h_region == 2'd1 || h_region == 2'd3));

  // R9: turnaround request ends a frame
  a_r9_bta_end: assert property (@(posedge clk) disable iff (!rst_n)
    bta_req |=> (frame_start || !active));

  // R10: stopping the run goes idle next cycle
  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !active);
endmodule

bind dvt_vid_timing dvt_vid_timing_chk #(.PW(PW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .active      (active),
  .v_region    (v_region),
  .h_region    (h_region),
  .frame_start (frame_start),
  .line_start  (line_start),
  .pkt_start   (pkt_start),
  .pkt_px      (pkt_px),
  .lp_ok       (lp_ok),
  .bta_req     (bta_req)
);

// File: tb/test_dvt_vid_timing.sv
`timescale 1ns/1ps
module test_dvt_vid_timing;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int PW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic [HW-1:0] cfg_hsa = '0, cfg_hbp = '0, cfg_hact = '0, cfg_hline = '0;
  logic [VW-1:0] cfg_vsa = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
  logic [PW-1:0] cfg_pkt_px = '0;
  logic [5:0]    cfg_lp_en = '0;
  logic          cfg_bta_en = 1'b0;

  logic          active, frame_start, line_start, pkt_start, lp_ok, bta_req;
  logic [1:0]    v_region, h_region;
  logic [PW-1:0] pkt_px;

  always #4 clk = ~clk;

  dvt_vid_timing #(.HW(HW), .VW(VW), .PW(PW)) i_dvt_vid_timing (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hline(cfg_hline),
    .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .cfg_pkt_px(cfg_pkt_px), .cfg_lp_en(cfg_lp_en), .cfg_bta_en(cfg_bta_en),
    .active(active), .v_region(v_region), .h_region(h_region),
    .frame_start(frame_start), .line_start(line_start), .pkt_start(pkt_start),
    .pkt_px(pkt_px), .lp_ok(lp_ok), .bta_req(bta_req)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model
  int m_run = 0, m_hc = 0, m_vl = 0;
  int s_hsa = 0, s_hbp = 0, s_hact = 0, s_hline = 0;
  int s_vsa = 0, s_vbp = 0, s_vact = 0, s_vfp = 0;
  int s_px = 0, s_lp = 0, s_bta = 0;

  function automatic int region_of(int p, int a, int b, int c);
    if (p < a) return 0;
    if (p < a + b) return 1;
    if (p < a + b + c) return 2;
    return 3;
  endfunction

  function automatic int line_len();
    return (s_hline < 1) ? 1 : s_hline;
  endfunction

  function automatic int frame_len();
    int t = s_vsa + s_vbp + s_vact + s_vfp;
    return (t < 1) ? 1 : t;
  endfunction

  task automatic model_load();
    s_hsa = cfg_hsa; s_hbp = cfg_hbp; s_hact = cfg_hact; s_hline = cfg_hline;
    s_vsa = cfg_vsa; s_vbp = cfg_vbp; s_vact = cfg_vact; s_vfp = cfg_vfp;
    s_px = cfg_pkt_px; s_lp = cfg_lp_en; s_bta = cfg_bta_en;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_hc = 0; m_vl = 0;
    end else if (!run_en) begin
      m_run = 0; m_hc = 0; m_vl = 0;
    end else if (m_run == 0) begin
      m_run = 1; m_hc = 0; m_vl = 0;
      model_load();
    end else if (m_hc == line_len() - 1) begin
      m_hc = 0;
      if (m_vl == frame_len() - 1) begin
        m_vl = 0;
        model_load();
      end else begin
        m_vl = m_vl + 1;
      end
    end else begin
      m_hc = m_hc + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int e_h, e_v, e_ls, e_fs, e_pkt, e_px, e_lp, e_bta;
      e_h = 0; e_v = 0; e_ls = 0; e_fs = 0; e_pkt = 0; e_px = 0; e_lp = 0; e_bta = 0;
      if (m_run != 0) begin
        e_h  = region_of(m_hc, s_hsa, s_hbp, s_hact);
        e_v  = region_of(m_vl, s_vsa, s_vbp, s_vact);
        e_ls = (m_hc == 0);
        e_fs = (m_hc == 0 && m_vl == 0);
        e_pkt = (e_v == 2 && s_hact > 0 && m_hc == s_hsa + s_hbp);
        e_px = e_pkt ? s_px : 0;
        case (e_v)
          0: e_lp = s_lp[0];
          1: e_lp = s_lp[1];
          3: e_lp = s_lp[3];
          default: e_lp = s_lp[2] && ((e_h == 1 && s_lp[4]) || (e_h == 3 && s_lp[5]));
        endcase
        e_bta = s_bta && (m_hc == line_len() - 1) && (m_vl == frame_len() - 1);
      end
      chk(active == m_run[0],     "R2 active",      active, m_run);
      chk(frame_start == e_fs[0], "R2 frame_start", frame_start, e_fs);
      chk(h_region == e_h[1:0],   "R3 h_region",    h_region, e_h);
      chk(line_start == e_ls[0],  "R3 line_start",  line_start, e_ls);
      chk(v_region == e_v[1:0],   "R4 v_region",    v_region, e_v);
      chk(pkt_start == e_pkt[0],  "R7 pkt_start",   pkt_start, e_pkt);
      chk(pkt_px == PW'(e_px),    "R7 pkt_px",      pkt_px, e_px);
      chk(lp_ok == e_lp[0],       "R8 lp_ok",       lp_ok, e_lp);
      chk(bta_req == e_bta[0],    "R9 bta_req",     bta_req, e_bta);
    end
  end

  // ---------------- stimulus helpers
  task automatic set_cfg(input int hsa, input int hbp, input int hact, input int hline,
                         input int vsa, input int vbp, input int vact, input int vfp,
                         input int px, input int lp, input int bta);
    cfg_hsa = HW'(hsa); cfg_hbp = HW'(hbp); cfg_hact = HW'(hact); cfg_hline = HW'(hline);
    cfg_vsa = VW'(vsa); cfg_vbp = VW'(vbp); cfg_vact = VW'(vact); cfg_vfp = VW'(vfp);
    cfg_pkt_px = PW'(px); cfg_lp_en = 6'(lp); cfg_bta_en = bta[0];
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      chk(1'b0, "R2 watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!active && v_region == 0 && h_region == 0 && !pkt_start && !lp_ok && !bta_req,
        "R1 reset quiet", active, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!active, "R1 idle after reset", active, 0);

    // configuration A, start: R2 first cycle is a frame start
    set_cfg(3, 4, 6, 20, 2, 2, 3, 2, 640, 6'b110101, 1);
    run_en = 1'b1;
    @(negedge clk);
    chk(frame_start && line_start && active, "R2 start next cycle", frame_start, 1);

    // R6: change config 30 cycles into a 180-cycle frame
    repeat (30) @(negedge clk);
    set_cfg(2, 3, 5, 12, 1, 1, 2, 1, 100, 6'b011010, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start);
    chk(n == 150, "R6 mid-frame change deferred", n, 150);
    repeat (2) wait_fs();

    // clipped line: active region lies beyond the line end (R7)
    set_cfg(4, 4, 10, 6, 1, 0, 2, 1, 77, 6'b111111, 1);
    wait_fs();
    n = pkt_start;
    repeat (23) begin @(negedge clk); n += pkt_start; end
    chk(n == 0, "R7 no strobe when active falls outside line", n, 0);

    // zero-length regions (R5)
    set_cfg(0, 0, 5, 8, 0, 0, 2, 0, 321, 0, 0);
    wait_fs();
    wait_fs();
    chk(h_region == 2 && v_region == 2, "R5 empty regions skipped", {v_region, h_region}, 4'b1010);
    chk(pkt_start && pkt_px == 321, "R7 strobe at first cycle", pkt_px, 321);

    // all zero: one-cycle frames (R4, R8, R9)
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 9, 6'b001000, 1);
    wait_fs();
    wait_fs();
    @(negedge clk);
    chk(frame_start, "R4 one-line one-cycle frame", frame_start, 1);
    chk(v_region == 3, "R4 empty frame is front porch", v_region, 3);
    chk(bta_req, "R9 request on last frame cycle", bta_req, 1);
    chk(lp_ok, "R8 front porch enable bit 3", lp_ok, 1);

    // R10: stop mid-run, then restart from zero
    set_cfg(3, 4, 6, 20, 2, 2, 3, 2, 640, 6'b110101, 1);
    wait_fs();
    repeat (45) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    chk(!active && v_region == 0, "R10 idle after stop", active, 0);
    repeat (3) @(negedge clk);
    chk(!active, "R10 stays idle", active, 0);
    run_en = 1'b1;
    @(negedge clk);
    chk(frame_start, "R10 restart from frame start", frame_start, 1);
    repeat (2) wait_fs();
    finish_run();
  end
endmodule